// File: doc/BRIEF.md
# Functional Unit Issue Controller

This block stands between a dependency-tracking scheduler and one functional unit, and it tracks a single operation from issue to write-back. When the unit is free, an issue strobe captures an opcode and two source operands, and the controller goes busy. It then asks for a register read and waits for a one-cycle read grant. The grant locks the captured operands and pulses a start strobe to the functional unit. When the unit reports done, the controller captures the result and asks for a write. An active-low shadow input holds that write request back while the result is still speculative. A one-cycle write grant drives the held result onto the result bus in that same cycle and frees the controller for the next issue.

The three acceptance points (issue, read grant, write grant) follow a fixed rotation. A kill input returns the controller to idle from any point and sends a one-cycle cancel strobe to the functional unit. The controller ignores any strobe that arrives out of turn.

Top module: `fu_issue_ctrl`

## Requirements
- R1: After synchronous reset, busy_o, rd_req_o, wr_req_o, fu_start_o, fu_cancel_o, result_vld_o, result_o and the operand outputs are all zero.
- R2: An issue_i sampled while busy_o is low sets busy_o and rd_req_o in the following cycle. The same clock edge captures opcode_i, src_a_i and src_b_i onto fu_op_o, fu_a_o and fu_b_o.
- R3: An issue_i sampled while busy_o is high is ignored. busy_o stays high and the operand outputs keep their values.
- R4: rd_req_o stays high until rd_go_i is sampled with it, and it falls in the very next cycle. In that next cycle fu_start_o is high for exactly one cycle. An rd_go_i sampled while rd_req_o is low has no effect.
- R5: Once busy, changes on opcode_i, src_a_i and src_b_i do not change fu_op_o, fu_a_o or fu_b_o.
- R6: fu_done_i sampled after the start (while neither request is up) stores fu_result_i and raises wr_req_o in the next cycle if shadow_n_i is high. fu_done_i at any other time is ignored.
- R7: While shadow_n_i is sampled low, wr_req_o is low in the next cycle. The held result is kept, and wr_req_o rises one cycle after shadow_n_i is sampled high.
- R8: In a cycle where wr_go_i and wr_req_o are both high, result_o equals the held result and result_vld_o is 1, both combinationally. In every other cycle both are zero. wr_req_o and busy_o fall in the next cycle.
- R9: In any cycle, at most one of these is accepted: an issue (issue_i with busy_o low), a read grant (rd_go_i with rd_req_o) or a write grant (wr_go_i with wr_req_o). A new issue is accepted in the first cycle after busy_o falls.
- R10: die_i sampled high clears busy_o, rd_req_o, wr_req_o and fu_start_o in the next cycle. fu_cancel_o pulses for one cycle in that next cycle only if busy_o was high when die_i was sampled. die_i overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe |
| opcode_i | input | OP_W | Opcode to capture on issue |
| src_a_i | input | DATA_W | First source operand |
| src_b_i | input | DATA_W | Second source operand |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | 1 | Register read request |
| rd_go_i | input | 1 | Read grant, one cycle |
| wr_req_o | output | 1 | Result write request |
| wr_go_i | input | 1 | Write grant, one cycle |
| shadow_n_i | input | 1 | Active-low write hold |
| die_i | input | 1 | Kill current operation |
| fu_start_o | output | 1 | Start pulse to functional unit |
| fu_cancel_o | output | 1 | Cancel pulse to functional unit |
| fu_op_o | output | OP_W | Held opcode |
| fu_a_o | output | DATA_W | Held first operand |
| fu_b_o | output | DATA_W | Held second operand |
| fu_done_i | input | 1 | Functional unit completion |
| fu_result_i | input | DATA_W | Functional unit result |
| result_o | output | DATA_W | Result bus, valid during write grant |
| result_vld_o | output | 1 | Result bus valid |

## Verification
Every registered result is due one clock edge after the input that causes it. The checks cover busy and read request after issue, the start pulse and the read request drop after a read grant, the write request after done or after shadow release, busy release after a write grant, and the cancel pulse after a kill. The bench changes inputs on the falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. result_o and result_vld_o are combinational during the write grant, so they are checked about one nanosecond after the grant is driven and before the rising edge that accepts it.

// File: rtl/fu_ctrl_pkg.sv
package fu_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } fu_state_e;
endpackage

// File: rtl/fu_seq.sv
module fu_seq
  import fu_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic rd_go_i,
  input  logic wr_go_i,
  input  logic shadow_n_i,
  input  logic die_i,
  input  logic fu_done_i,
  output logic busy_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic fu_start_o,
  output logic fu_cancel_o,
  output logic load_opnd_o,
  output logic load_res_o,
  output logic wr_take_o
);
  fu_state_e state_q, state_d;
  logic busy_q, rd_req_q, wr_req_q, start_q, cancel_q;
  logic issue_take, rd_take, wr_take, done_take;

  assign issue_take = issue_i && (state_q == ST_IDLE) && !die_i;
  assign rd_take    = rd_go_i && rd_req_q && !die_i;
  assign wr_take    = wr_go_i && wr_req_q && !die_i;
  assign done_take  = fu_done_i && (state_q == ST_EXEC) && !die_i;

  always_comb begin
    state_d = state_q;
    if (die_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (issue_take) state_d = ST_READ;
        ST_READ:  if (rd_take)    state_d = ST_EXEC;
        ST_EXEC:  if (done_take)  state_d = ST_WRITE;
        ST_WRITE: if (wr_take)    state_d = ST_IDLE;
        default:                  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy_q   <= 1'b0;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      start_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      busy_q   <= (state_d != ST_IDLE);
      rd_req_q <= (state_d == ST_READ);
      wr_req_q <= (state_d == ST_WRITE) && shadow_n_i;
      start_q  <= rd_take;
      cancel_q <= die_i && busy_q;
    end
  end

  assign busy_o      = busy_q;
  assign rd_req_o    = rd_req_q;
  assign wr_req_o    = wr_req_q;
  assign fu_start_o  = start_q;
  assign fu_cancel_o = cancel_q;
  assign load_opnd_o = issue_take;
  assign load_res_o  = done_take;
  assign wr_take_o   = wr_take;
endmodule

// File: rtl/fu_opnd_hold.sv
module fu_opnd_hold #(
  parameter int OP_W   = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  localparam int PACK_W = OP_W + 2 * DATA_W;
  logic [PACK_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load_i) begin
      hold_q <= {op_i, a_i, b_i};
    end
  end

  assign {op_o, a_o, b_o} = hold_q;
endmodule

// File: rtl/fu_result_hold.sv
module fu_result_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              grant_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o
);
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (load_i) begin
      res_q <= din_i;
    end
  end

  assign result_o     = grant_i ? res_q : '0;
  assign result_vld_o = grant_i;
endmodule

// File: rtl/fu_issue_ctrl.sv
module fu_issue_ctrl #(
  parameter int OP_W   = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              busy_o,
  output logic              rd_req_o,
  input  logic              rd_go_i,
  output logic              wr_req_o,
  input  logic              wr_go_i,
  input  logic              shadow_n_i,
  input  logic              die_i,
  output logic              fu_start_o,
  output logic              fu_cancel_o,
  output logic [OP_W-1:0]   fu_op_o,
  output logic [DATA_W-1:0] fu_a_o,
  output logic [DATA_W-1:0] fu_b_o,
  input  logic              fu_done_i,
  input  logic [DATA_W-1:0] fu_result_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o
);
  logic load_opnd, load_res, wr_take;

  fu_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .rd_go_i    (rd_go_i),
    .wr_go_i    (wr_go_i),
    .shadow_n_i (shadow_n_i),
    .die_i      (die_i),
    .fu_done_i  (fu_done_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .wr_req_o   (wr_req_o),
    .fu_start_o (fu_start_o),
    .fu_cancel_o(fu_cancel_o),
    .load_opnd_o(load_opnd),
    .load_res_o (load_res),
    .wr_take_o  (wr_take)
  );

  fu_opnd_hold #(.OP_W(OP_W), .DATA_W(DATA_W)) i_opnd (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_opnd),
    .op_i  (opcode_i),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .op_o  (fu_op_o),
    .a_o   (fu_a_o),
    .b_o   (fu_b_o)
  );

  fu_result_hold #(.DATA_W(DATA_W)) i_res (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_res),
    .din_i       (fu_result_i),
    .grant_i     (wr_take),
    .result_o    (result_o),
    .result_vld_o(result_vld_o)
  );
endmodule

// File: rtl/fu_issue_ctrl_chk.sv
module fu_issue_ctrl_chk #(
  parameter int OP_W   = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_i,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic              rd_go_i,
  input logic              wr_req_o,
  input logic              wr_go_i,
  input logic              shadow_n_i,
  input logic              die_i,
  input logic              fu_start_o,
  input logic              fu_cancel_o,
  input logic [DATA_W-1:0] fu_a_o,
  input logic [DATA_W-1:0] result_o,
  input logic              result_vld_o
);
  a_r2_issue_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && issue_i && !die_i) |=> (busy_o && rd_req_o));

  a_r4_rdreq_drops: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_go_i) |=> !rd_req_o);

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_go_i && !die_i) |=> fu_start_o);

  a_r5_operands_locked: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(fu_a_o));

  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    !shadow_n_i |=> !wr_req_o);

  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !(wr_go_i && wr_req_o) |-> (result_o == '0 && !result_vld_o));

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o && wr_go_i) |=> (!wr_req_o && !busy_o));

  a_r9_one_accept: assert property (@(posedge clk) disable iff (rst)
    $onehot0({issue_i && !busy_o, rd_go_i && rd_req_o, wr_go_i && wr_req_o}));

  a_r9_reqs_need_busy: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o || wr_req_o) |-> (busy_o && !(rd_req_o && wr_req_o)));

  a_r10_kill_clears: assert property (@(posedge clk) disable iff (rst)
    die_i |=> (!busy_o && !rd_req_o && !wr_req_o && !fu_start_o));

  a_r10_cancel_pulse: assert property (@(posedge clk) disable iff (rst)
    (die_i && busy_o) |=> fu_cancel_o);

  a_r10_no_stray_cancel: assert property (@(posedge clk) disable iff (rst)
    !(die_i && busy_o) |=> !fu_cancel_o);
endmodule

bind fu_issue_ctrl fu_issue_ctrl_chk #(.OP_W(OP_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_fu_issue_ctrl.sv
`timescale 1ns/1ps
module test_fu_issue_ctrl;
  localparam int OP_W   = 6;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst;
  logic issue_i, rd_go_i, wr_go_i, shadow_n_i, die_i, fu_done_i;
  logic [OP_W-1:0]   opcode_i;
  logic [DATA_W-1:0] src_a_i, src_b_i, fu_result_i;
  logic busy_o, rd_req_o, wr_req_o, fu_start_o, fu_cancel_o, result_vld_o;
  logic [OP_W-1:0]   fu_op_o;
  logic [DATA_W-1:0] fu_a_o, fu_b_o, result_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fu_issue_ctrl #(.OP_W(OP_W), .DATA_W(DATA_W)) i_fu_issue_ctrl (
    .clk(clk), .rst(rst), .issue_i(issue_i), .opcode_i(opcode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .busy_o(busy_o), .rd_req_o(rd_req_o),
    .rd_go_i(rd_go_i), .wr_req_o(wr_req_o), .wr_go_i(wr_go_i),
    .shadow_n_i(shadow_n_i), .die_i(die_i), .fu_start_o(fu_start_o),
    .fu_cancel_o(fu_cancel_o), .fu_op_o(fu_op_o), .fu_a_o(fu_a_o),
    .fu_b_o(fu_b_o), .fu_done_i(fu_done_i), .fu_result_i(fu_result_i),
    .result_o(result_o), .result_vld_o(result_vld_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    issue_i = 0; rd_go_i = 0; wr_go_i = 0; die_i = 0; fu_done_i = 0;
    shadow_n_i = 1;
  endtask

  task automatic do_issue(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] a,
                          input logic [DATA_W-1:0] b);
    issue_i = 1; opcode_i = op; src_a_i = a; src_b_i = b;
    step();
    issue_i = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    opcode_i = '1; src_a_i = '1; src_b_i = '1; fu_result_i = '1;
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    chk("R1 busy", busy_o, 0);
    chk("R1 reqs", {rd_req_o, wr_req_o}, 0);
    chk("R1 strobes", {fu_start_o, fu_cancel_o, result_vld_o}, 0);
    chk("R1 buses", {fu_op_o, fu_a_o ^ fu_b_o, result_o}, 0);
  endtask

  task automatic t_basic();
    do_issue(6'd3, 32'h1111_0001, 32'h2222_0002);
    chk("R2 busy", busy_o, 1);
    chk("R2 rd_req", rd_req_o, 1);
    chk("R2 operands", {fu_op_o, fu_a_o, fu_b_o}, {6'd3, 32'h1111_0001, 32'h2222_0002});
    src_a_i = 32'h9999_9999; opcode_i = 6'd9;
    step(); step();
    chk("R4 rd_req held", rd_req_o, 1);
    chk("R4 no early start", fu_start_o, 0);
    rd_go_i = 1;
    step();
    rd_go_i = 0;
    chk("R4 rd_req drop", rd_req_o, 0);
    chk("R4 start pulse", fu_start_o, 1);
    issue_i = 1; src_a_i = 32'h7777_7777; src_b_i = 32'h8888_8888;
    step();
    issue_i = 0;
    chk("R4 start one cycle", fu_start_o, 0);
    chk("R3 busy kept", busy_o, 1);
    chk("R5 operands locked", {fu_op_o, fu_a_o, fu_b_o}, {6'd3, 32'h1111_0001, 32'h2222_0002});
    fu_done_i = 1; fu_result_i = 32'hABCD_1234;
    step();
    fu_done_i = 0; fu_result_i = 32'h0;
    chk("R6 wr_req", wr_req_o, 1);
    #1;
    chk("R8 quiet bus", {result_vld_o, result_o}, 0);
    wr_go_i = 1;
    #1;
    chk("R8 bus on grant", {result_vld_o, result_o}, {1'b1, 32'hABCD_1234});
    step();
    wr_go_i = 0;
    chk("R8 release", {busy_o, wr_req_o}, 0);
  endtask

  task automatic t_stray();
    rd_go_i = 1; wr_go_i = 1; fu_done_i = 1; fu_result_i = 32'h5555_5555;
    #1;
    chk("R8 stray grant quiet", {result_vld_o, result_o}, 0);
    step();
    rd_go_i = 0; wr_go_i = 0; fu_done_i = 0;
    chk("R4 stray rd_go", {busy_o, rd_req_o, fu_start_o}, 0);
    chk("R6 stray done", wr_req_o, 0);
    do_issue(6'd1, 32'h10, 32'h20);
    fu_done_i = 1;
    step();
    fu_done_i = 0;
    chk("R6 done before start ignored", {rd_req_o, wr_req_o}, 2'b10);
    rd_go_i = 1; step(); rd_go_i = 0;
    fu_done_i = 1; fu_result_i = 32'h0000_00AA; step(); fu_done_i = 0;
    fu_result_i = 32'hFFFF_FFFF;
    fu_done_i = 1; step(); fu_done_i = 0;
    wr_go_i = 1; #1;
    chk("R6 late done ignored", result_o, 32'h0000_00AA);
    step(); wr_go_i = 0;
  endtask

  task automatic t_shadow();
    do_issue(6'd5, 32'h3, 32'h4);
    rd_go_i = 1; step(); rd_go_i = 0;
    shadow_n_i = 0;
    fu_done_i = 1; fu_result_i = 32'hCAFE_0005; step(); fu_done_i = 0;
    chk("R7 wr_req held low", wr_req_o, 0);
    wr_go_i = 1; #1;
    chk("R7 grant without req", result_vld_o, 0);
    step(); wr_go_i = 0;
    step(); step();
    chk("R7 still held", {busy_o, wr_req_o}, 2'b10);
    shadow_n_i = 1;
    step();
    chk("R7 release", wr_req_o, 1);
    wr_go_i = 1; #1;
    chk("R7 result kept", result_o, 32'hCAFE_0005);
    step(); wr_go_i = 0;
    chk("R8 release after shadow", busy_o, 0);
  endtask

  task automatic t_die();
    do_issue(6'd7, 32'h6, 32'h7);
    rd_go_i = 1; step(); rd_go_i = 0;
    die_i = 1; step(); die_i = 0;
    chk("R10 cleared", {busy_o, rd_req_o, wr_req_o, fu_start_o}, 0);
    chk("R10 cancel", fu_cancel_o, 1);
    fu_done_i = 1; step(); fu_done_i = 0;
    chk("R10 cancel one cycle", fu_cancel_o, 0);
    chk("R10 done after kill ignored", wr_req_o, 0);
    die_i = 1; step(); die_i = 0;
    chk("R10 idle kill no cancel", fu_cancel_o, 0);
    do_issue(6'd8, 32'h8, 32'h9);
    die_i = 1; rd_go_i = 1; step(); die_i = 0; rd_go_i = 0;
    chk("R10 kill beats grant", {busy_o, fu_start_o, fu_cancel_o}, 3'b001);
  endtask

  task automatic t_back_to_back();
    do_issue(6'd2, 32'hA, 32'hB);
    rd_go_i = 1; step(); rd_go_i = 0;
    fu_done_i = 1; fu_result_i = 32'h0BAD_F00D; step(); fu_done_i = 0;
    wr_go_i = 1; issue_i = 1; opcode_i = 6'd4; src_a_i = 32'hC; src_b_i = 32'hD;
    step();
    wr_go_i = 0; issue_i = 0;
    chk("R9 issue during grant ignored", {busy_o, fu_a_o}, {1'b0, 32'hA});
    do_issue(6'd4, 32'hC, 32'hD);
    chk("R9 reissue after free", {busy_o, rd_req_o, fu_a_o}, {2'b11, 32'hC});
    die_i = 1; step(); die_i = 0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stray();
    t_shadow();
    t_die();
    t_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule